// File: doc/BRIEF.md
# Serial Double-Word Shift, Rotate and Normalize Engine

This block shifts a 48-bit value formed from two 24-bit words, a high word A and a low word B, by one bit position per clock. It provides an arithmetic right shift, a right rotate, a left shift that reports sign changes, a left rotate, and a normalize operation. Normalize moves the pair left until the two top bits of A differ. While it does so it counts down a 24-bit index value once for each position moved.

A caller presents the direction, a 2-bit mode, a 6-bit position limit, both words and the index value, then pulses `start`. The engine takes one cycle to capture the operands. It then moves one position per cycle and spends one final cycle finishing, so an operation of N positions takes 2 + N cycles. When it finishes, it pulses `done` for one cycle. In the same cycle it may pulse `ovf_set`. The results, the number of positions actually moved and a flag marking an illegal direction/mode pair stay steady on the outputs until the next operation.

Top module: `dshift_top`

## Requirements
- R1: After synchronous reset, `a_out`, `b_out`, `x_out` and `shifts_done` are zero, and `done`, `ovf_set` and `illegal_mode` are low.
- R2: `done` goes high for exactly one cycle, N+2 rising edges after the rising edge that samples `start`, counting that edge as the first. N is the number of positions actually moved. A limit of 0 moves nothing and leaves A, B and X unchanged.
- R3: Right shift (`dir_left`=0, `mode`=2'b00) gives the 48-bit value {A,B} shifted right arithmetically by the limit. The top bit of A is replicated into vacated positions, the low bit of A passes into the top bit of B, and bits leaving the bottom of B are lost. X is unchanged.
- R4: Right rotate (`dir_left`=0, `mode`=2'b10) rotates {A,B} right by the limit. The bottom bit of B enters the top of A, so no bit is lost. X is unchanged.
- R5: Left shift (`dir_left`=1, `mode`=2'b00) shifts {A,B} left by the limit. The top bit of B passes into the bottom of A, and zeros fill from the bottom of B. X is unchanged.
- R6: `ovf_set` pulses together with `done` exactly when, during a left shift, any bit entering the top of A differs from A's top bit at start. It never pulses for any other operation.
- R7: Left rotate (`dir_left`=1, `mode`=2'b10) rotates {A,B} left by the limit. The top bit of A enters the bottom of B. X is unchanged.
- R8: Normalize (`dir_left`=1, `mode`=2'b01) checks, before each move, whether A[23] differs from A[22]. It moves {A,B} left with zero fill while those bits are equal and the limit is not used up. X is decremented modulo 2^24 once per move.
- R9: `shifts_done` reports the number of positions actually moved. That is the limit for every mode except normalize, where it may be smaller.
- R10: `illegal_mode` is high from `done` until the next accepted start when the pair is right with 2'b01 or any direction with 2'b11. Right with 2'b01 acts as a plain right shift, and left with 2'b11 acts as a plain left shift.
- R11: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its own result and gives a single `done`.
- R12: Octal vectors: right shift 18 of 45261237/27651260 gives 77777745/26123727. Left shift 18 of 46712370/64132711 gives 70641327/11000000. Left rotate 9 of 76543210/01234567 gives 43210012/34567765. Normalize with limit 24 of 00004632/76124035 and X=0 gives 23153705/20164000 and X=77777765.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| dir_left | input | 1 | 1 = left, 0 = right |
| mode | input | 2 | 00 shift, 10 rotate, 01 normalize |
| count | input | 6 | Position limit |
| a_in | input | 24 | High word operand |
| b_in | input | 24 | Low word operand |
| x_in | input | 24 | Index operand |
| a_out | output | 24 | High word result |
| b_out | output | 24 | Low word result |
| x_out | output | 24 | Index result |
| ovf_set | output | 1 | One-cycle sign-change report with done |
| done | output | 1 | One-cycle completion pulse |
| shifts_done | output | 6 | Positions actually moved |
| illegal_mode | output | 1 | Illegal direction/mode pair seen |

## Verification
A wrong position counter shows up as a `done` that comes early or late, and as a `shifts_done` that disagrees with the limit. Both are visible at the very next completion. A fault in the per-mode bit routing changes specific bits of `a_out` or `b_out`. The sweep over every limit from 0 to 63 in each direction/mode pair exposes this on the first limit that carries the wrong bit across the word boundary. A faulty sticky sign comparison or normalize stop test shows as a missing or spurious `ovf_set`, or as the wrong `x_out` and move count, in the same completion cycle.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
  localparam int WORD_W = 24;
  localparam int CNT_W  = 6;

  typedef enum logic [2:0] {
    OP_SHR = 3'd0,
    OP_CYR = 3'd1,
    OP_SHL = 3'd2,
    OP_CYL = 3'd3,
    OP_NRM = 3'd4
  } dsh_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dsh_state_e;
endpackage

// File: rtl/dshift_decode.sv
module dshift_decode
  import dshift_pkg::*;
(
  input  logic       dir_left,
  input  logic [1:0] mode,
  output dsh_op_e    op,
  output logic       illegal
);
  always_comb begin
    op      = OP_SHR;
    illegal = 1'b0;
    if (!dir_left) begin
      unique case (mode)
        2'b10:   op = OP_CYR;
        2'b00:   op = OP_SHR;
        default: begin op = OP_SHR; illegal = 1'b1; end
      endcase
    end else begin
      unique case (mode)
        2'b00:   op = OP_SHL;
        2'b10:   op = OP_CYL;
        2'b01:   op = OP_NRM;
        default: begin op = OP_SHL; illegal = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/dshift_datapath.sv
module dshift_datapath
  import dshift_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  dsh_op_e      op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] x_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] x_q,
  output logic         norm_stop,
  output logic         ovf_seen
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pair;
  logic [PW-1:0] pair_nxt;
  logic          sign0;
  logic          enter_bit;

  assign pair      = {a_q, b_q};
  assign enter_bit = a_q[W-2];
  assign norm_stop = (op == OP_NRM) && (a_q[W-1] != a_q[W-2]);

  always_comb begin
    unique case (op)
      OP_SHR:  pair_nxt = {pair[PW-1], pair[PW-1:1]};
      OP_CYR:  pair_nxt = {pair[0], pair[PW-1:1]};
      OP_CYL:  pair_nxt = {pair[PW-2:0], pair[PW-1]};
      default: pair_nxt = {pair[PW-2:0], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      x_q      <= '0;
      sign0    <= 1'b0;
      ovf_seen <= 1'b0;
    end else if (load) begin
      a_q      <= a_in;
      b_q      <= b_in;
      x_q      <= x_in;
      sign0    <= a_in[W-1];
      ovf_seen <= 1'b0;
    end else if (step) begin
      {a_q, b_q} <= pair_nxt;
      if (op == OP_NRM) x_q <= x_q - 1'b1;
      if (op == OP_SHL && enter_bit != sign0) ovf_seen <= 1'b1;
    end
  end

  // R3: arithmetic right shift keeps the top bit of A
  a_r3_sign_hold: assert property (@(posedge clk) disable iff (rst)
    (step && op == OP_SHR) |=> (a_q[W-1] == $past(a_q[W-1])));

  // R4 R7: rotation preserves the number of ones in the pair
  a_r4_r7_rot_ones: assert property (@(posedge clk) disable iff (rst)
    (step && (op == OP_CYR || op == OP_CYL)) |=>
      ($countones({a_q, b_q}) == $past($countones({a_q, b_q}))));

  // R8: each normalize move decrements the index by one
  a_r8_index_dec: assert property (@(posedge clk) disable iff (rst)
    (step && op == OP_NRM) |=> (x_q == $past(x_q) - 1'b1));

  // R3 R5: modes other than normalize leave the index alone
  a_r5_index_hold: assert property (@(posedge clk) disable iff (rst)
    (step && op != OP_NRM) |=> $stable(x_q));

  // R6: the sign-change record is raised only by left shifts
  a_r6_ovf_only_shl: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_seen) |-> ($past(op) == OP_SHL && $past(step)));
endmodule

// File: rtl/dshift_ctrl.sv
module dshift_ctrl
  import dshift_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  dsh_op_e       dec_op,
  input  logic          dec_illegal,
  input  logic          norm_stop,
  input  logic          ovf_seen,
  output logic          load,
  output logic          step,
  output dsh_op_e       op_q,
  output logic          illegal_q,
  output logic [CW-1:0] shifts_q,
  output logic          done_q,
  output logic          ovf_q
);
  dsh_state_e    st;
  logic [CW-1:0] remain;
  logic [CW-1:0] limit_q;
  logic          finish;

  assign load   = (st == ST_IDLE) && start;
  assign finish = (st == ST_RUN) && (remain == '0 || norm_stop);
  assign step   = (st == ST_RUN) && !finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      remain    <= '0;
      limit_q   <= '0;
      shifts_q  <= '0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
      op_q      <= OP_SHR;
      illegal_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      if (load) begin
        st        <= ST_RUN;
        remain    <= count;
        limit_q   <= count;
        shifts_q  <= '0;
        op_q      <= dec_op;
        illegal_q <= dec_illegal;
      end else if (finish) begin
        st     <= ST_IDLE;
        done_q <= 1'b1;
        ovf_q  <= ovf_seen;
      end else if (step) begin
        remain   <= remain - 1'b1;
        shifts_q <= shifts_q + 1'b1;
      end
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6: the sign-change report only accompanies completion
  a_r6_ovf_with_done: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> done_q);

  // R9: moves never exceed the captured limit
  a_r9_moves_bounded: assert property (@(posedge clk) disable iff (rst)
    shifts_q <= limit_q);

  // R11: a start while running does not reload the limit
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && start) |=> $stable(limit_q));
endmodule

// File: rtl/dshift_top.sv
module dshift_top
  import dshift_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_left,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] count,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  x_in,
  output logic [W-1:0]  a_out,
  output logic [W-1:0]  b_out,
  output logic [W-1:0]  x_out,
  output logic          ovf_set,
  output logic          done,
  output logic [CW-1:0] shifts_done,
  output logic          illegal_mode
);
  dsh_op_e dec_op;
  dsh_op_e op_q;
  logic    dec_illegal;
  logic    load;
  logic    step;
  logic    norm_stop;
  logic    ovf_seen;

  dshift_decode u_dec (
    .dir_left (dir_left),
    .mode     (mode),
    .op       (dec_op),
    .illegal  (dec_illegal)
  );

  dshift_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .count       (count),
    .dec_op      (dec_op),
    .dec_illegal (dec_illegal),
    .norm_stop   (norm_stop),
    .ovf_seen    (ovf_seen),
    .load        (load),
    .step        (step),
    .op_q        (op_q),
    .illegal_q   (illegal_mode),
    .shifts_q    (shifts_done),
    .done_q      (done),
    .ovf_q       (ovf_set)
  );

  dshift_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .op        (op_q),
    .a_in      (a_in),
    .b_in      (b_in),
    .x_in      (x_in),
    .a_q       (a_out),
    .b_q       (b_out),
    .x_q       (x_out),
    .norm_stop (norm_stop),
    .ovf_seen  (ovf_seen)
  );
endmodule

// File: tb/tb_dshift_top.sv
module tb_dshift_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir_left = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [5:0]  count = '0;
  logic [23:0] a_in = '0, b_in = '0, x_in = '0;
  logic [23:0] a_out, b_out, x_out;
  logic        ovf_set, done, illegal_mode;
  logic [5:0]  shifts_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dshift_top dut (
    .clk(clk), .rst(rst), .start(start), .dir_left(dir_left), .mode(mode),
    .count(count), .a_in(a_in), .b_in(b_in), .x_in(x_in),
    .a_out(a_out), .b_out(b_out), .x_out(x_out), .ovf_set(ovf_set),
    .done(done), .shifts_done(shifts_done), .illegal_mode(illegal_mode)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_case(input logic dl, input logic [1:0] md, input int cnt,
                          input logic [23:0] a, input logic [23:0] b,
                          input logic [23:0] x, input bit busy_poke);
    logic [47:0] v;
    logic [23:0] ex;
    logic        sgn, ovf, ill;
    int          n, edges, op;
    bit          got;
    // op: 0 SHR 1 CYR 2 SHL 3 CYL 4 NRM (R10 mapping)
    ill = (md == 2'b11) || (!dl && md == 2'b01);
    if (!dl) op = (md == 2'b10) ? 1 : 0;
    else op = (md == 2'b10) ? 3 : (md == 2'b01) ? 4 : 2;
    v = {a, b}; ex = x; sgn = a[23]; ovf = 1'b0; n = 0;
    for (int k = 0; k < cnt; k++) begin
      if (op == 4 && v[47] != v[46]) break;
      case (op)
        0: v = {v[47], v[47:1]};
        1: v = {v[0], v[47:1]};
        3: v = {v[46:0], v[47]};
        default: begin
          if (op == 2 && v[46] != sgn) ovf = 1'b1;
          v = {v[46:0], 1'b0};
          if (op == 4) ex = ex - 1;
        end
      endcase
      n++;
    end
    @(negedge clk);
    dir_left = dl; mode = md; count = cnt[5:0]; a_in = a; b_in = b; x_in = x;
    start = 1'b1;
    edges = 0; got = 0;
    for (int t = 0; t < 200 && !got; t++) begin
      @(posedge clk); edges++;
      @(negedge clk);
      start = 1'b0;
      if (busy_poke && edges == 4) begin
        start = 1'b1; dir_left = 1'b0; mode = 2'b10; count = 6'd3;
        a_in = ~a; b_in = ~b; x_in = ~x;
      end
      if (busy_poke && edges == 5) start = 1'b0;
      if (done) begin
        got = 1;
        chk("R2 latency", 48'(edges), 48'(n + 2));
        chk("R3 R4 R5 R7 R8 A", {24'd0, a_out}, {24'd0, v[47:24]});
        chk("R3 R4 R5 R7 R8 B", {24'd0, b_out}, {24'd0, v[23:0]});
        chk("R8 X", {24'd0, x_out}, {24'd0, ex});
        chk("R6 ovf_set", {47'd0, ovf_set}, {47'd0, ovf});
        chk("R9 shifts_done", {42'd0, shifts_done}, 48'(n));
        chk("R10 illegal_mode", {47'd0, illegal_mode}, {47'd0, ill});
      end
    end
    chk("R2 done seen", {47'd0, got}, 48'd1);
    start = 1'b0;
    @(negedge clk);
    chk("R2 done one cycle", {47'd0, done}, 48'd0);
    chk("R6 ovf_set one cycle", {47'd0, ovf_set}, 48'd0);
    if (busy_poke) begin
      int extra = 0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11 single done", 48'(extra), 48'd0);
      chk("R11 result kept A", {24'd0, a_out}, {24'd0, v[47:24]});
    end
  endtask

  initial begin
    logic [23:0] pa [4];
    logic [23:0] pb [4];
    logic [23:0] px [4];
    logic        dls [7];
    logic [1:0]  mds [7];
    pa[0] = 24'o45261237; pb[0] = 24'o27651260; px[0] = 24'o00000005;
    pa[1] = 24'o00004632; pb[1] = 24'o76124035; px[1] = 24'o00000000;
    pa[2] = 24'o77770000; pb[2] = 24'o00007777; px[2] = 24'o40000000;
    pa[3] = 24'o37777777; pb[3] = 24'o70000001; px[3] = 24'o12345670;
    dls[0] = 0; mds[0] = 2'b00;
    dls[1] = 0; mds[1] = 2'b10;
    dls[2] = 0; mds[2] = 2'b01;
    dls[3] = 1; mds[3] = 2'b00;
    dls[4] = 1; mds[4] = 2'b10;
    dls[5] = 1; mds[5] = 2'b01;
    dls[6] = 1; mds[6] = 2'b11;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 a_out", {24'd0, a_out}, 48'd0);
    chk("R1 b_out", {24'd0, b_out}, 48'd0);
    chk("R1 x_out", {24'd0, x_out}, 48'd0);
    chk("R1 shifts_done", {42'd0, shifts_done}, 48'd0);
    chk("R1 flags", {45'd0, done, ovf_set, illegal_mode}, 48'd0);

    // R12 fixed octal vectors
    run_case(0, 2'b00, 18, 24'o45261237, 24'o27651260, 0, 0);
    chk("R12 rsh A", {24'd0, a_out}, {24'd0, 24'o77777745});
    chk("R12 rsh B", {24'd0, b_out}, {24'd0, 24'o26123727});
    run_case(1, 2'b00, 18, 24'o46712370, 24'o64132711, 0, 0);
    chk("R12 lsh A", {24'd0, a_out}, {24'd0, 24'o70641327});
    chk("R12 lsh B", {24'd0, b_out}, {24'd0, 24'o11000000});
    run_case(1, 2'b10, 9, 24'o76543210, 24'o01234567, 0, 0);
    chk("R12 lcy A", {24'd0, a_out}, {24'd0, 24'o43210012});
    chk("R12 lcy B", {24'd0, b_out}, {24'd0, 24'o34567765});
    run_case(1, 2'b01, 24, 24'o00004632, 24'o76124035, 0, 0);
    chk("R12 nod A", {24'd0, a_out}, {24'd0, 24'o23153705});
    chk("R12 nod B", {24'd0, b_out}, {24'd0, 24'o20164000});
    chk("R12 nod X", {24'd0, x_out}, {24'd0, 24'o77777765});

    // R11 start while busy
    run_case(1, 2'b00, 20, pa[0], pb[0], px[0], 1);

    // Sweep every limit, every direction/mode pair, several patterns
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 7; m++)
        for (int c = 0; c < 64; c++)
          run_case(dls[m], mds[m], c, pa[p], pb[p], px[p], 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule